// File: doc/BRIEF.md
# Key-Chained Entropy Seed Mixer

This block turns raw entropy into 128-bit seed words. Two independent entropy sources each offer 32-bit words over a valid/ready handshake. The mixer takes one word from each source at the same time and packs the pair into a 64-bit block. Four such blocks make one 256-bit message. Each message is hashed with an internal keyed pseudo-random function that has the SipHash-2-4 structure and produces a 128-bit digest.

Messages alternate between two roles. The first message after reset, and every second message after it, is a re-key message. Its digest replaces the mixer key and never leaves the block. The message that follows is hashed under that fresh key, and its digest is presented as a seed word on a valid/ready output toward a seed queue. The key is the only state that carries over from one message to the next.

If the downstream queue does not take a seed, the block still absorbs the next re-key message. It then holds off before starting the following seed message.

Top module: `seed_mixer`

## Requirements
- R1: After reset `seed_valid` is low and the key equals the `INIT_KEY` parameter (default bytes 00..0f little-endian, i.e. k0 = 64'h0706050403020100, k1 = 64'h0f0e0d0c0b0a0908). The first re-key message is hashed under this key.
- R2: Entropy is consumed only in pairs. A handshake on one source happens only in a cycle with a handshake on the other. A word offered alone is not accepted.
- R3: The n-th accepted pair (n = 0..3) of a message forms block n = {source B word, source A word}, with source A in bits 31:0. The digest is SipHash-2-4 in 128-bit mode over these 32 bytes: v1 is XORed with 0xee at init, a closing block 64'h2000000000000000 follows, 0xee goes into v2 before the first four finalisation rounds, and 0xdd goes into v1 before the second four.
- R4: A re-key message (the 1st, 3rd, 5th, ... after reset) never raises `seed_valid`.
- R5: A seed message (the 2nd, 4th, ...) is hashed under the current key and presented as `seed_data` = {out1, out0}, with out0 in bits 63:0. The key halves map as k0 = key[63:0] and k1 = key[127:64].
- R6: The digest of a re-key message, computed under the previous key, becomes the new key (key chaining).
- R7: While `seed_valid` is high and `seed_ready` is low, `seed_valid` stays high and `seed_data` does not change.
- R8: While a seed is pending, the next re-key message is still absorbed. The seed message after it accepts no entropy until the pending seed is taken.
- R9: A seed message leaves the key unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_a_data | input | 32 | Source A entropy word |
| ent_a_valid | input | 1 | Source A word offered |
| ent_a_ready | output | 1 | Source A word taken |
| ent_b_data | input | 32 | Source B entropy word |
| ent_b_valid | input | 1 | Source B word offered |
| ent_b_ready | output | 1 | Source B word taken |
| seed_data | output | 128 | Seed word |
| seed_valid | output | 1 | Seed word available |
| seed_ready | input | 1 | Seed queue takes the word |

## Verification
The assertions assume that each source keeps its word and its valid signal steady until the word is taken. They also assume that `seed_ready` is a plain level that needs no particular timing. The bench drives inputs only on falling edges and lowers a valid only after the handshake cycle. The skewed-arrival cases raise one valid several cycles before the other without ever pulling it back. Back-pressure is produced by holding `seed_ready` low across two full messages, so the stall point is reached with a fully formed re-key message already absorbed.

// File: rtl/seed_mixer.sv
module seed_mixer #(
  parameter int unsigned  C_ROUNDS = 2,
  parameter int unsigned  D_ROUNDS = 4,
  parameter logic [127:0] INIT_KEY = 128'h0f0e0d0c0b0a09080706050403020100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  ent_a_data,
  input  logic         ent_a_valid,
  output logic         ent_a_ready,
  input  logic [31:0]  ent_b_data,
  input  logic         ent_b_valid,
  output logic         ent_b_ready,
  output logic [127:0] seed_data,
  output logic         seed_valid,
  input  logic         seed_ready
);

  localparam int unsigned MAXR = (C_ROUNDS > D_ROUNDS) ? C_ROUNDS : D_ROUNDS;
  localparam int unsigned RW   = $clog2(MAXR + 1);
  localparam logic [63:0] TAIL = 64'h2000000000000000;
  localparam logic [63:0] IV0  = 64'h736f6d6570736575;
  localparam logic [63:0] IV1  = 64'h646f72616e646f6d;
  localparam logic [63:0] IV2  = 64'h6c7967656e657261;
  localparam logic [63:0] IV3  = 64'h7465646279746573;

  typedef enum logic [1:0] {S_START, S_COLLECT, S_COMP, S_FIN} st_t;

  st_t            st;
  logic [127:0]   key;
  logic           key_phase;
  logic [255:0]   v, rv;
  logic [63:0]    m, lo, fold;
  logic [2:0]     blk;
  logic [RW-1:0]  rnd;
  logic           fin2, take;

  function automatic logic [255:0] sip_round(input logic [255:0] s);
    logic [63:0] a, b, c, d;
    {d, c, b, a} = s;
    a = a + b; b = {b[50:0], b[63:51]}; b = b ^ a; a = {a[31:0], a[63:32]};
    c = c + d; d = {d[47:0], d[63:48]}; d = d ^ c;
    a = a + d; d = {d[42:0], d[63:43]}; d = d ^ a;
    c = c + b; b = {b[46:0], b[63:47]}; b = b ^ c; c = {c[31:0], c[63:32]};
    return {d, c, b, a};
  endfunction

  assign rv          = sip_round(v);
  assign fold        = rv[63:0] ^ rv[127:64] ^ rv[191:128] ^ rv[255:192];
  assign ent_a_ready = (st == S_COLLECT) && ent_b_valid;
  assign ent_b_ready = (st == S_COLLECT) && ent_a_valid;
  assign take        = (st == S_COLLECT) && ent_a_valid && ent_b_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_START;
      key        <= INIT_KEY;
      key_phase  <= 1'b1;
      seed_valid <= 1'b0;
      seed_data  <= '0;
      v          <= '0;
      m          <= '0;
      lo         <= '0;
      blk        <= '0;
      rnd        <= '0;
      fin2       <= 1'b0;
    end else begin
      if (seed_valid && seed_ready) seed_valid <= 1'b0;
      case (st)
        S_START: if (key_phase || !seed_valid) begin
          v    <= {key[127:64] ^ IV3, key[63:0] ^ IV2,
                   key[127:64] ^ IV1 ^ 64'hee, key[63:0] ^ IV0};
          blk  <= '0;
          fin2 <= 1'b0;
          st   <= S_COLLECT;
        end
        S_COLLECT: if (take) begin
          m            <= {ent_b_data, ent_a_data};
          v[255:192]   <= v[255:192] ^ {ent_b_data, ent_a_data};
          rnd          <= '0;
          st           <= S_COMP;
        end
        S_COMP: begin
          v   <= rv;
          rnd <= rnd + 1'b1;
          if (rnd == RW'(C_ROUNDS - 1)) begin
            v[63:0] <= rv[63:0] ^ m;
            rnd     <= '0;
            if (blk == 3'd4) begin
              v[191:128] <= rv[191:128] ^ 64'hee;
              st         <= S_FIN;
            end else if (blk == 3'd3) begin
              m          <= TAIL;
              v[255:192] <= rv[255:192] ^ TAIL;
              blk        <= 3'd4;
            end else begin
              blk <= blk + 1'b1;
              st  <= S_COLLECT;
            end
          end
        end
        S_FIN: begin
          v   <= rv;
          rnd <= rnd + 1'b1;
          if (rnd == RW'(D_ROUNDS - 1)) begin
            rnd <= '0;
            if (!fin2) begin
              lo         <= fold;
              v[127:64]  <= rv[127:64] ^ 64'hdd;
              fin2       <= 1'b1;
            end else begin
              if (key_phase) key <= {fold, lo};
              else begin
                seed_data  <= {fold, lo};
                seed_valid <= 1'b1;
              end
              key_phase <= ~key_phase;
              st        <= S_START;
            end
          end
        end
        default: st <= S_START;
      endcase
    end
  end

  p_pair_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_a_valid && ent_a_ready) == (ent_b_valid && ent_b_ready));

  p_rekey_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_valid) |-> $past(!key_phase));

  p_key_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key) |-> $past(st == S_FIN) && $past(key_phase));

  p_seed_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid && !seed_ready |=> seed_valid && $stable(seed_data));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid && !key_phase |-> !ent_a_ready && !ent_b_ready);

  p_key_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seed_valid) |-> $stable(key));

endmodule

// File: tb/test_seed_mixer.sv
`timescale 1ns/1ps
module test_seed_mixer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  a_data = '0, b_data = '0;
  logic         a_valid = 1'b0, b_valid = 1'b0, seed_ready = 1'b0;
  logic         a_ready, b_ready, seed_valid;
  logic [127:0] seed_data;

  int checks = 0, errors = 0;
  logic [127:0] ref_key = 128'h0f0e0d0c0b0a09080706050403020100;
  logic [31:0]  lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  seed_mixer i_seed_mixer (
    .clk(clk), .rst_n(rst_n),
    .ent_a_data(a_data), .ent_a_valid(a_valid), .ent_a_ready(a_ready),
    .ent_b_data(b_data), .ent_b_valid(b_valid), .ent_b_ready(b_ready),
    .seed_data(seed_data), .seed_valid(seed_valid), .seed_ready(seed_ready)
  );

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic void mix(ref logic [63:0] w0, w1, w2, w3);
    w0 += w1; w1 = rotl(w1, 13) ^ w0; w0 = rotl(w0, 32);
    w2 += w3; w3 = rotl(w3, 16) ^ w2;
    w0 += w3; w3 = rotl(w3, 21) ^ w0;
    w2 += w1; w1 = rotl(w1, 17) ^ w2; w2 = rotl(w2, 32);
  endfunction

  function automatic logic [127:0] prf(input logic [127:0] k, input logic [255:0] msg);
    logic [63:0] w0, w1, w2, w3, blkv, o0;
    w0 = k[63:0]   ^ 64'h736f6d6570736575;
    w1 = k[127:64] ^ 64'h646f72616e646f6d ^ 64'hee;
    w2 = k[63:0]   ^ 64'h6c7967656e657261;
    w3 = k[127:64] ^ 64'h7465646279746573;
    for (int i = 0; i < 5; i++) begin
      blkv = (i < 4) ? msg[64*i +: 64] : 64'h2000000000000000;
      w3 ^= blkv;
      for (int r = 0; r < 2; r++) mix(w0, w1, w2, w3);
      w0 ^= blkv;
    end
    w2 ^= 64'hee;
    for (int r = 0; r < 4; r++) mix(w0, w1, w2, w3);
    o0 = w0 ^ w1 ^ w2 ^ w3;
    w1 ^= 64'hdd;
    for (int r = 0; r < 4; r++) mix(w0, w1, w2, w3);
    return {w0 ^ w1 ^ w2 ^ w3, o0};
  endfunction

  function automatic logic [255:0] mk_msg();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      r[32*i +: 32] = lcg;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // lead > 0: A offered first for lead cycles; lead < 0: B first
  task automatic send_pair(input logic [31:0] a, input logic [31:0] b, input int lead);
    @(negedge clk);
    a_data = a; b_data = b;
    if (lead != 0) begin
      if (lead > 0) a_valid = 1'b1; else b_valid = 1'b1;
      for (int c = 0; c < (lead > 0 ? lead : -lead); c++) begin
        #1;
        chk(!(a_valid && a_ready) && !(b_valid && b_ready), "R2",
            {a_ready, b_ready}, 0);
        @(negedge clk);
      end
    end
    a_valid = 1'b1; b_valid = 1'b1;
    for (int c = 0; c < 400; c++) begin
      #1;
      if (a_ready && b_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  task automatic send_msg(input logic [255:0] msg, input int lead);
    for (int i = 0; i < 4; i++)
      send_pair(msg[64*i +: 32], msg[64*i+32 +: 32], lead);
  endtask

  task automatic get_seed(input logic [127:0] exp, input string req);
    bit got = 0;
    @(negedge clk);
    seed_ready = 1'b1;
    for (int c = 0; c < 400; c++) begin
      if (seed_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got && seed_data == exp, req, seed_data, exp);
    @(posedge clk);
    @(negedge clk);
    seed_ready = 1'b0;
  endtask

  task automatic rekey(input logic [255:0] msg, input int lead);
    send_msg(msg, lead);
    ref_key = prf(ref_key, msg);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(seed_valid == 1'b0, "R1", seed_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(a_ready == 1'b0 && b_ready == 1'b0, "R2", {a_ready, b_ready}, 0);
  endtask

  task automatic t_first_seed();
    logic [255:0] m1 = mk_msg(), m2 = mk_msg();
    seed_ready = 1'b1;
    rekey(m1, 0);
    repeat (40) @(negedge clk);
    chk(seed_valid == 1'b0, "R4", seed_valid, 0);
    seed_ready = 1'b0;
    send_msg(m2, 0);
    get_seed(prf(ref_key, m2), "R1 R3 R5");
  endtask

  task automatic t_chain();
    logic [255:0] m3 = mk_msg(), m4 = mk_msg();
    rekey(m3, 0);
    send_msg(m4, 0);
    get_seed(prf(ref_key, m4), "R6 R9");
  endtask

  task automatic t_skew();
    logic [255:0] m5 = mk_msg(), m6 = mk_msg();
    rekey(m5, 3);
    send_msg(m6, -2);
    get_seed(prf(ref_key, m6), "R2 R3");
  endtask

  task automatic t_backpressure();
    logic [255:0] m7 = mk_msg(), m8 = mk_msg(), m9 = mk_msg(), m10 = mk_msg();
    logic [127:0] e8;
    seed_ready = 1'b0;
    rekey(m7, 0);
    send_msg(m8, 0);
    e8 = prf(ref_key, m8);
    rekey(m9, 0);
    for (int c = 0; c < 100 && !seed_valid; c++) @(negedge clk);
    a_data = m10[31:0]; b_data = m10[63:32];
    a_valid = 1'b1; b_valid = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      #1;
      chk(!a_ready && !b_ready, "R8", {a_ready, b_ready}, 0);
      chk(seed_valid && seed_data == e8, "R7", seed_data, e8);
    end
    get_seed(e8, "R7");
    send_msg(m10, 0);
    get_seed(prf(ref_key, m10), "R8 R6");
  endtask

  task automatic t_patterns();
    logic [255:0] z = '0, o = '1;
    logic [255:0] lanes = {8{32'h0}};
    rekey(z, 0);
    send_msg(o, 0);
    get_seed(prf(ref_key, o), "R3 R5");
    lanes[31:0] = 32'hdead_beef;
    rekey(o, 0);
    send_msg(lanes, 1);
    get_seed(prf(ref_key, lanes), "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_seed();
    t_chain();
    t_skew();
    t_backpressure();
    t_patterns();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule